// File: doc/BRIEF.md
# Audio DAC Power Sequencer

This controller puts the output stage of a stereo audio DAC through power-up and power-down. It drives only control lines: the outputs say when the stage is in low power, when the outputs are held at ground, when the level ramp runs (with one step pulse per frame), when audio may play, and when the soft discharge sink replaces the drivers. The analog ramp, the sink and the configuration registers are outside the block. Long intervals are measured in left/right frame periods, marked by a one-cycle `frame_tick` strobe. The short interval with pop suppression off is measured in master-clock cycles.

A strap selects how power-up is started. In pin mode, power-up follows the release of the reset pin after a startup wait whose length depends on the sample-rate speed mode. In register mode, power-up waits for a power-down bit to be cleared. With pop suppression on, the outputs are clamped, then ramped, and only then is audio allowed. Going into power-down stops audio and enables the discharge sink for a fixed number of frames. A new power-up waits until that discharge has finished.

The reset pin is sampled synchronously. Its low level is itself one of the power-down triggers, and a discharge in progress runs to completion while it is held low.

Top module: `dac_pwr_seq`

## Requirements
- R1: While `rst_n` is low and no discharge is running, the outputs show the idle state: `low_power`=1 and `clamp_en`, `ramp_active`, `ramp_step`, `audio_en` and `sink_en` all 0. The pin acts at the next clock edge.
- R2: In pin mode (`mode_reg`=0), once `rst_n` is high, `low_power` stays 1 for a startup wait before power-up begins. The wait is WAIT_BASE frame ticks for `speed_sel`=00, twice that for 01, and four times that for both 10 and 11.
- R3: `speed_sel` is captured once, when the startup wait begins. Later changes do not alter that wait.
- R4: In register mode (`mode_reg`=1), the block remains in low power as long as `pd_bit`=1. It starts power-up after exactly one idle cycle once `pd_bit`=0, with no startup wait.
- R5: When power-up starts with `pop_en`=0, all six outputs are 0 for FAST_US microseconds. That interval is MCLK_HZ*FAST_US/1e6 clock cycles. `audio_en` then goes to 1.
- R6: When power-up starts with `pop_en`=1, `clamp_en` is 1 for CLAMP_FRAMES frame ticks, then `ramp_active` is 1 for RAMP_FRAMES frame ticks, then `audio_en` goes to 1. `pop_en` is sampled when power-up starts.
- R7: During the ramp, `ramp_step` pulses once for each frame tick, which gives exactly RAMP_FRAMES pulses per ramp. It is never high outside the ramp.
- R8: In any powered state (fast interval, clamp, ramp or audio), `rst_n`=0 or (in register mode) `pd_bit`=1 causes, at the next edge: `audio_en`=0, `clamp_en`=0, `ramp_active`=0, `sink_en`=1 and `low_power`=1.
- R9: `sink_en` stays 1 for exactly DISCH_FRAMES frame ticks. A power-up request made during the discharge is held pending. It is acted on after one idle cycle once `sink_en` falls.
- R10: In pin mode `pd_bit` has no effect. Playing audio continues whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset pin, sampled synchronously |
| pd_bit | input | 1 | Power-down setting from the register block (register mode only) |
| mode_reg | input | 1 | Strap: 0 = pin mode, 1 = register mode |
| speed_sel | input | 2 | Speed mode: 00 single, 01 double, 10/11 quad |
| pop_en | input | 1 | Pop-suppression enable |
| frame_tick | input | 1 | One-cycle strobe per left/right frame |
| low_power | output | 1 | Stage in low power (quiescent reference low) |
| clamp_en | output | 1 | Clamp outputs to ground |
| ramp_active | output | 1 | Level ramp in progress |
| ramp_step | output | 1 | One pulse per frame during the ramp |
| audio_en | output | 1 | Audio output enabled |
| sink_en | output | 1 | Soft discharge sink enabled |

## Verification
The outputs are decoded directly from the registered state, so a wrong state appears on the ports in the same cycle it is reached. A wrong dwell count does not change which outputs are active. It only moves the edge at which they change, so the bench measures every dwell in frame ticks or clock cycles and compares it with the exact value. A stuck or skipped state shows up as a missing or unexpected output change, or as a wrong number of ramp step pulses. A lost pending request shows up as a power-up that never starts after discharge.

// File: rtl/dac_pseq_pkg.sv
package dac_pseq_pkg;

    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_WAIT  = 3'd1,
        PS_QUICK = 3'd2,
        PS_CLAMP = 3'd3,
        PS_RAMP  = 3'd4,
        PS_PLAY  = 3'd5,
        PS_DRAIN = 3'd6
    } pseq_state_e;

    function automatic int pseq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_pseq_span.sv
module dac_pseq_span #(
    parameter int WAIT_BASE = 512,
    parameter int CNT_W     = 12
) (
    input  logic [1:0]       speed,
    output logic [CNT_W-1:0] span
);
    localparam logic [CNT_W-1:0] SPAN_X1 = CNT_W'(WAIT_BASE);
    localparam logic [CNT_W-1:0] SPAN_X2 = CNT_W'(2 * WAIT_BASE);
    localparam logic [CNT_W-1:0] SPAN_X4 = CNT_W'(4 * WAIT_BASE);

    // Encoding 2'b11 is folded into quad speed.
    always_comb begin
        case (speed)
            2'b00:   span = SPAN_X1;
            2'b01:   span = SPAN_X2;
            default: span = SPAN_X4;
        endcase
    end
endmodule

// File: rtl/dac_pseq_decode.sv
module dac_pseq_decode
    import dac_pseq_pkg::*;
(
    input  pseq_state_e st,
    input  logic        frame_tick,
    output logic        low_power,
    output logic        clamp_en,
    output logic        ramp_active,
    output logic        ramp_step,
    output logic        audio_en,
    output logic        sink_en
);
    always_comb begin
        low_power   = (st == PS_IDLE) || (st == PS_WAIT) || (st == PS_DRAIN);
        clamp_en    = (st == PS_CLAMP);
        ramp_active = (st == PS_RAMP);
        ramp_step   = (st == PS_RAMP) && frame_tick;
        audio_en    = (st == PS_PLAY);
        sink_en     = (st == PS_DRAIN);
    end
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
    import dac_pseq_pkg::*;
#(
    parameter int WAIT_BASE    = 512,
    parameter int MCLK_HZ      = 12_288_000,
    parameter int FAST_US      = 50,
    parameter int CLAMP_FRAMES = 1000,
    parameter int RAMP_FRAMES  = 10000,
    parameter int DISCH_FRAMES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_bit,
    input  logic       mode_reg,
    input  logic [1:0] speed_sel,
    input  logic       pop_en,
    input  logic       frame_tick,
    output logic       low_power,
    output logic       clamp_en,
    output logic       ramp_active,
    output logic       ramp_step,
    output logic       audio_en,
    output logic       sink_en
);
    localparam longint FAST_L   = (longint'(MCLK_HZ) * longint'(FAST_US)) / 64'd1000000;
    localparam int     FAST_CYC = (FAST_L < 1) ? 1 : int'(FAST_L);
    localparam int     MAX_SPAN = pseq_max(pseq_max(4 * WAIT_BASE, FAST_CYC),
                                  pseq_max(pseq_max(CLAMP_FRAMES, RAMP_FRAMES), DISCH_FRAMES));
    localparam int     CNT_W    = $clog2(MAX_SPAN + 1);

    localparam logic [CNT_W-1:0] FAST_LAST  = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] CLAMP_LAST = CNT_W'(CLAMP_FRAMES - 1);
    localparam logic [CNT_W-1:0] RAMP_LAST  = CNT_W'(RAMP_FRAMES - 1);
    localparam logic [CNT_W-1:0] DISCH_LAST = CNT_W'(DISCH_FRAMES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        pseq_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       spd;
    } ctl_t;

    ctl_t             cur_q;
    ctl_t             nxt_d;
    logic [CNT_W-1:0] span;
    logic             off_req;

    dac_pseq_span #(
        .WAIT_BASE(WAIT_BASE),
        .CNT_W    (CNT_W)
    ) u_span (
        .speed(cur_q.spd),
        .span (span)
    );

    always_comb begin
        off_req = !rst_n || (mode_reg && pd_bit);
        nxt_d   = cur_q;
        case (cur_q.st)
            PS_IDLE: begin
                nxt_d.cnt = '0;
                if (rst_n) begin
                    if (!mode_reg) begin
                        nxt_d.st  = PS_WAIT;
                        nxt_d.spd = speed_sel;
                    end else if (!pd_bit) begin
                        nxt_d.st = pop_en ? PS_CLAMP : PS_QUICK;
                    end
                end
            end
            PS_WAIT: begin
                if (!rst_n) begin
                    nxt_d.st  = PS_IDLE;
                    nxt_d.cnt = '0;
                end else if (frame_tick) begin
                    if (cur_q.cnt == span - CNT_ONE) begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = pop_en ? PS_CLAMP : PS_QUICK;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_ONE;
                    end
                end
            end
            PS_QUICK, PS_CLAMP, PS_RAMP, PS_PLAY: begin
                if (off_req) begin
                    nxt_d.st  = PS_DRAIN;
                    nxt_d.cnt = '0;
                end else if (cur_q.st == PS_QUICK) begin
                    if (cur_q.cnt == FAST_LAST) begin
                        nxt_d.st  = PS_PLAY;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_ONE;
                    end
                end else if (cur_q.st == PS_CLAMP && frame_tick) begin
                    if (cur_q.cnt == CLAMP_LAST) begin
                        nxt_d.st  = PS_RAMP;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_ONE;
                    end
                end else if (cur_q.st == PS_RAMP && frame_tick) begin
                    if (cur_q.cnt == RAMP_LAST) begin
                        nxt_d.st  = PS_PLAY;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_ONE;
                    end
                end
            end
            PS_DRAIN: begin
                if (frame_tick) begin
                    if (cur_q.cnt == DISCH_LAST) begin
                        nxt_d.st  = PS_IDLE;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_ONE;
                    end
                end
            end
            default: begin
                nxt_d.st  = PS_IDLE;
                nxt_d.cnt = '0;
                nxt_d.spd = 2'b00;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    dac_pseq_decode u_decode (
        .st         (cur_q.st),
        .frame_tick (frame_tick),
        .low_power  (low_power),
        .clamp_en   (clamp_en),
        .ramp_active(ramp_active),
        .ramp_step  (ramp_step),
        .audio_en   (audio_en),
        .sink_en    (sink_en)
    );

    AST_PD_STOPS_AUDIO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg && pd_bit && !low_power) |=> (sink_en && !audio_en && !clamp_en && !ramp_active)) // R8
        else $error("power-down bit did not start discharge");

    AST_PIN_KEEPS_AUDIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_reg && audio_en) |=> audio_en) // R10
        else $error("audio dropped in pin mode");

    AST_CLAMP_FROM_LOW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_en) |-> $past(low_power)) // R6
        else $error("clamp entered from a powered state");

    AST_AUDIO_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(audio_en) |-> (!$past(low_power) && !$past(clamp_en))) // R5
        else $error("audio enabled without settle interval");

    AST_RAMP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ramp_active) |-> (audio_en || sink_en)) // R7
        else $error("ramp left to an unexpected state");

    AST_SINK_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sink_en) |-> $past(frame_tick)) // R9
        else $error("discharge ended without a frame tick");

endmodule

// File: tb/dac_pwr_seq_test.sv
module dac_pwr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WB = 8;
    localparam int FASTN = 10;
    localparam int CLN = 4;
    localparam int RPN = 6;
    localparam int DSN = 5;

    localparam logic [4:0] V_LP    = 5'b00001;
    localparam logic [4:0] V_FAST  = 5'b00000;
    localparam logic [4:0] V_CLAMP = 5'b00010;
    localparam logic [4:0] V_RAMP  = 5'b00100;
    localparam logic [4:0] V_PLAY  = 5'b01000;
    localparam logic [4:0] V_DISCH = 5'b10001;

    logic clk = 1'b0;
    logic rst_n, pd_bit, mode_reg, pop_en, frame_tick;
    logic [1:0] speed_sel;
    logic low_power, clamp_en, ramp_active, ramp_step, audio_en, sink_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic mark = 1'b0;
    logic monitor_on = 1'b0;

    typedef struct {
        logic [4:0] vec;
        int         kind;
        int         val;
        string      req;
    } exp_t;
    exp_t q[$];

    dac_pwr_seq #(
        .WAIT_BASE(WB), .MCLK_HZ(200_000), .FAST_US(50),
        .CLAMP_FRAMES(CLN), .RAMP_FRAMES(RPN), .DISCH_FRAMES(DSN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pd_bit(pd_bit), .mode_reg(mode_reg),
        .speed_sel(speed_sel), .pop_en(pop_en), .frame_tick(frame_tick),
        .low_power(low_power), .clamp_en(clamp_en), .ramp_active(ramp_active),
        .ramp_step(ramp_step), .audio_en(audio_en), .sink_en(sink_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        frame_tick = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            frame_tick = ((cyc % 4) == 0);
        end
    end

    function automatic logic [4:0] outv();
        return {sink_en, audio_en, ramp_active, clamp_en, low_power};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [4:0] v, input int kind, input int val, input string req);
        exp_t e;
        e.vec = v; e.kind = kind; e.val = val; e.req = req;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_vec(input logic [4:0] v);
        while (outv() != v) step(1);
    endtask

    // Release the reset pin right after a frame tick so the first cycles carry none.
    task automatic release_quiet();
        step(1);
        while (frame_tick != 1'b1) step(1);
        step(1);
        rst_n = 1'b1;
        mark = 1'b1;
        step(1);
        mark = 1'b0;
    endtask

    // Monitor: measures each output dwell and compares it with the queued expectation.
    initial begin
        logic [4:0] prev;
        int ticks, cycles, steps;
        exp_t e;
        wait (monitor_on);
        @(negedge clk);
        prev = outv();
        ticks = 0; cycles = 0; steps = 0;
        forever begin
            @(negedge clk);
            if (mark) begin
                ticks = 0; cycles = 0; steps = 0;
            end
            if (outv() != prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected output change", int'(outv()), int'(prev));
                end else begin
                    e = q.pop_front();
                    chk(e.vec == prev, e.req, "dwell output vector", int'(prev), int'(e.vec));
                    if (e.kind == 1) chk(ticks == e.val, e.req, "dwell frame ticks", ticks, e.val);
                    if (e.kind == 2) chk(cycles == e.val, e.req, "dwell clock cycles", cycles, e.val);
                    if (e.vec == V_RAMP) chk(steps == e.val, "R7", "ramp step pulses", steps, e.val);
                end
                ticks = 0; cycles = 0; steps = 0;
            end
            cycles++;
            if (frame_tick) ticks++;
            if (ramp_step) steps++;
            prev = outv();
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pd_bit = 1'b1; mode_reg = 1'b0; speed_sel = 2'b00; pop_en = 1'b0;
        step(6);
        chk(outv() == V_LP && !ramp_step, "R1", "outputs in reset", int'(outv()), int'(V_LP));
        monitor_on = 1'b1;
        step(2);

        // Pin mode, single speed, no pop suppression
        push(V_LP, 1, WB, "R2");
        push(V_FAST, 2, FASTN, "R5");
        push(V_PLAY, 0, 0, "R5");
        release_quiet();
        wait_vec(V_PLAY);
        pd_bit = 1'b1;
        step(12);
        chk(audio_en == 1'b1, "R10", "audio with pd_bit in pin mode", int'(audio_en), 1);
        pd_bit = 1'b0;
        push(V_DISCH, 1, DSN, "R9");
        rst_n = 1'b0;
        step(1);
        chk(outv() == V_DISCH, "R8", "reset pin starts discharge", int'(outv()), int'(V_DISCH));
        wait_vec(V_LP);
        step(3);
        chk(outv() == V_LP, "R1", "idle after discharge in reset", int'(outv()), int'(V_LP));

        // Pin mode, double speed captured, later speed change ignored, pop on
        speed_sel = 2'b01; pop_en = 1'b1;
        push(V_LP, 1, 2 * WB, "R3");
        push(V_CLAMP, 1, CLN, "R6");
        push(V_RAMP, 1, RPN, "R7");
        push(V_PLAY, 0, 0, "R6");
        release_quiet();
        step(5);
        speed_sel = 2'b00;
        wait_vec(V_PLAY);
        push(V_DISCH, 1, DSN, "R8");
        rst_n = 1'b0;
        wait_vec(V_LP);

        // Pin mode, quad speed (10), no pop
        speed_sel = 2'b10; pop_en = 1'b0;
        push(V_LP, 1, 4 * WB, "R2");
        push(V_FAST, 2, FASTN, "R5");
        push(V_PLAY, 0, 0, "R5");
        release_quiet();
        wait_vec(V_PLAY);
        push(V_DISCH, 1, DSN, "R9");
        rst_n = 1'b0;
        wait_vec(V_LP);

        // Pin mode, speed code 11 treated as quad, pop on
        speed_sel = 2'b11; pop_en = 1'b1;
        push(V_LP, 1, 4 * WB, "R2");
        push(V_CLAMP, 1, CLN, "R6");
        push(V_RAMP, 1, RPN, "R7");
        push(V_PLAY, 0, 0, "R6");
        release_quiet();
        wait_vec(V_PLAY);
        push(V_DISCH, 1, DSN, "R8");
        rst_n = 1'b0;
        wait_vec(V_LP);

        // Register mode
        mode_reg = 1'b1; pd_bit = 1'b1; pop_en = 1'b0; speed_sel = 2'b00;
        rst_n = 1'b1;
        step(40);
        chk(outv() == V_LP, "R4", "low power while pd_bit set", int'(outv()), int'(V_LP));
        push(V_LP, 2, 1, "R4");
        push(V_FAST, 2, FASTN, "R5");
        push(V_PLAY, 0, 0, "R5");
        pd_bit = 1'b0;
        mark = 1'b1;
        step(1);
        mark = 1'b0;
        wait_vec(V_PLAY);
        push(V_DISCH, 1, DSN, "R9");
        push(V_LP, 2, 1, "R9");
        push(V_CLAMP, 1, CLN, "R6");
        push(V_RAMP, 1, RPN, "R7");
        push(V_PLAY, 0, 0, "R6");
        pd_bit = 1'b1;
        step(1);
        chk(outv() == V_DISCH, "R8", "pd_bit starts discharge", int'(outv()), int'(V_DISCH));
        step(2);
        pd_bit = 1'b0;
        pop_en = 1'b1;
        wait_vec(V_PLAY);
        push(V_DISCH, 1, DSN, "R8");
        pd_bit = 1'b1;
        wait_vec(V_LP);
        step(10);
        chk(q.size() == 0, "R8", "expected transitions left", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule